// File: doc/BRIEF.md
# Per-Lane Read Delay Calibrator

This block is a sequencer that finds a good setting for the adjustable input delay on each data lane of a DDR memory PHY. It runs when `start` is pulsed. First it opens row 0 of bank 0 and writes one burst of a fixed byte pattern. Then it calibrates the lanes one at a time. For each lane it resets the delay line and steps it up one tap at a time. At each tap it issues a test read and compares the returned bytes that belong to the lane against the pattern. It records the lowest tap that reads correctly. It then steps past that edge by a fixed margin and records the next tap that reads wrongly. Finally it resets the lane and steps it to the midpoint of the two edges.

When the last lane is centred, the sequencer closes the row with a precharge, waits for it to settle and pulses `done`. The edges it found for every lane stay on `min_taps` and `max_taps`. A single parameter picks between a short delay line and a long one. The short line has a 32-tap search limit and a 1-tap margin. The long line has a 512-tap limit and an 8-tap margin. The surrounding controller turns the four command pulses into DRAM commands. The activate and precharge commands always address row 0, bank 0.

Top module: `rdly_calibrator`

## Requirements
- R1: While reset is held, every command and delay pulse is low, `lane_sel` is 0, `busy` and `done` are 0, and every recorded tap is 0.
- R2: A `start` pulse while idle gives one `cmd_act` pulse. `cmd_wr` follows exactly 16 cycles later. While `cmd_wr` is high, byte i of `wr_data` (bits 8i+7..8i) is the low byte of the (i+1)-th value of the 32-bit generator v = 1664525*v + 1013904223 started at v = 42. Byte i lies in phase i/(2*LANES) at offset i%(2*LANES). No two of the four command pulses are ever high together.
- R3: Lanes are calibrated in the order n = 0, 1, ..., LANES-1. While lane n is calibrated, `lane_sel` is the one-hot mask 1 << (LANES-1-n), and each delay pulse has exactly one bit of `lane_sel` set.
- R4: Each lane's search starts with a single-cycle `dly_rst`. Every `cmd_rd` comes in the cycle right after a `dly_rst` or `dly_inc` pulse. No delay pulse occurs until the read's result has been taken.
- R5: The result of a read is taken from `rd_data` in the 16th cycle after the `cmd_rd` cycle.
- R6: A read passes for lane n when, in every phase p, the bytes at offsets n and n+LANES (byte indices p*2*LANES+n and p*2*LANES+n+LANES) equal the pattern. Bytes belonging to other lanes have no effect.
- R7: The min edge is the first tap, counting up from 0, whose read passes. The delay then takes MARGIN further increments. The max edge is the first tap after that whose read fails.
- R8: No read is issued once the tap count reaches MAX_TAP (32 by default). At that point the edge being sought is recorded as the current tap. A lane that never passes therefore records MAX_TAP and MAX_TAP+MARGIN.
- R9: After the max edge is found, the lane gets one `dly_rst` and then exactly (min+max)/2 `dly_inc` pulses, rounded down.
- R10: After the last lane, `cmd_pre` is pulsed. `done` is a single-cycle pulse exactly 16 cycles after `cmd_pre`. At that point `min_taps`/`max_taps` hold lane n's edges in field n (TAP_W bits each), with max >= min. `busy` then drops.
- R11: A `start` pulse while `busy` is high is ignored: a run issues exactly one activate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calibration run when idle |
| rd_data | input | PHASES*2*LANES*8 | Captured read bytes, byte i at bits 8i+7..8i |
| lane_sel | output | LANES | One-hot select of the delay line being adjusted |
| dly_rst | output | 1 | Reset the selected delay line to tap 0 |
| dly_inc | output | 1 | Advance the selected delay line by one tap |
| cmd_act | output | 1 | Request activate of row 0, bank 0 |
| cmd_wr | output | 1 | Request write of `wr_data` |
| cmd_rd | output | 1 | Request a test read |
| cmd_pre | output | 1 | Request precharge |
| wr_data | output | PHASES*2*LANES*8 | Test pattern bytes |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Pulse at the end of a run |
| min_taps | output | LANES*TAP_W | First passing tap per lane |
| max_taps | output | LANES*TAP_W | First failing tap past the margin per lane |

## Verification
Most internal faults show up within a single read. A wrong lane index or byte offset makes the sequencer judge a lane by bytes another lane owns. A wrong wait count makes it sample `rd_data` before or after the valid cycle. The bench drives inverted bytes in every cycle except the 16th after a read, so either fault moves a recorded edge, and the error is visible on `min_taps`/`max_taps` and on the final delay count as soon as `done` rises. A faulty phase flag or tap counter shows up the same way by the end of the run. Ordering faults, such as a read too soon after a pulse, a wrong select mask or a wrong command gap, are visible on the cycle they happen.

// File: rtl/rdly_pkg.sv
package rdly_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ACT,
        ST_ACT_WAIT,
        ST_WRITE,
        ST_LANE_SEL,
        ST_PROBE,
        ST_RD_WAIT,
        ST_EVAL,
        ST_STEP,
        ST_MARGIN,
        ST_CENTER_RST,
        ST_CENTER_INC,
        ST_PRE,
        ST_PRE_WAIT,
        ST_FINISH
    } cal_state_e;

    // One step of the 32-bit linear congruential generator used for the pattern
    function automatic logic [31:0] lcg_step(input logic [31:0] v);
        return v * 32'd1664525 + 32'd1013904223;
    endfunction

endpackage

// File: rtl/rdly_pattern.sv
module rdly_pattern #(
    parameter int LANES  = 4,
    parameter int PHASES = 4,
    localparam int NBYTES = PHASES * 2 * LANES
) (
    output logic [NBYTES*8-1:0] pattern_o
);
    import rdly_pkg::*;

    // Fixed byte sequence: low byte of each generator output, seed 42
    always_comb begin
        logic [31:0] state_v;
        state_v   = 32'd42;
        pattern_o = '0;
        for (int i = 0; i < NBYTES; i++) begin
            state_v = lcg_step(state_v);
            pattern_o[i*8 +: 8] = state_v[7:0];
        end
    end

endmodule

// File: rtl/rdly_match.sv
module rdly_match #(
    parameter int LANES  = 4,
    parameter int PHASES = 4,
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int DATA_W = PHASES * 2 * LANES * 8
) (
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic [DATA_W-1:0] pattern_i,
    input  logic [LANE_W-1:0] lane_i,
    output logic              lane_ok_o
);
    logic [PHASES-1:0] phase_ok;

    for (genvar p = 0; p < PHASES; p++) begin : g_phase
        localparam int BASE = p * 2 * LANES;
        logic [7:0] got_lo, got_hi, exp_lo, exp_hi;
        always_comb begin
            got_lo = rd_data_i[(BASE + int'(lane_i)) * 8 +: 8];
            got_hi = rd_data_i[(BASE + LANES + int'(lane_i)) * 8 +: 8];
            exp_lo = pattern_i[(BASE + int'(lane_i)) * 8 +: 8];
            exp_hi = pattern_i[(BASE + LANES + int'(lane_i)) * 8 +: 8];
        end
        assign phase_ok[p] = (got_lo == exp_lo) && (got_hi == exp_hi);
    end

    assign lane_ok_o = &phase_ok;

endmodule

// File: rtl/rdly_seq.sv
module rdly_seq #(
    parameter int LANES    = 4,
    parameter int MAX_TAP  = 32,
    parameter int MARGIN   = 1,
    parameter int WAIT_CYC = 15,
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int TAP_W  = $clog2(MAX_TAP + MARGIN + 1),
    localparam int WAIT_W = $clog2(WAIT_CYC + 1),
    localparam int CNT_W  = (TAP_W > WAIT_W) ? TAP_W : WAIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              lane_ok_i,
    output logic [LANE_W-1:0] lane_o,
    output logic              lane_active_o,
    output logic [TAP_W-1:0]  tap_o,
    output logic              rec_min_o,
    output logic              rec_max_o,
    output logic              dly_rst_o,
    output logic              dly_inc_o,
    output logic              cmd_act_o,
    output logic              cmd_wr_o,
    output logic              cmd_rd_o,
    output logic              cmd_pre_o,
    output logic              busy_o,
    output logic              done_o
);
    import rdly_pkg::*;

    typedef struct packed {
        cal_state_e        st;
        logic [LANE_W-1:0] lane;
        logic [TAP_W-1:0]  tap;
        logic [TAP_W-1:0]  lo;
        logic [CNT_W-1:0]  cnt;
        logic              hunt_fail;
    } seq_t;

    localparam seq_t SEQ_RST = '{st: ST_IDLE, default: '0};

    seq_t seq_d, seq_q;
    logic edge_hit;
    logic [TAP_W:0]   sum_w;
    logic [TAP_W-1:0] mid_w;

    assign sum_w = {1'b0, seq_q.lo} + {1'b0, seq_q.tap};
    assign mid_w = sum_w[TAP_W:1];

    always_comb begin
        seq_d     = seq_q;
        edge_hit  = 1'b0;
        rec_min_o = 1'b0;
        rec_max_o = 1'b0;
        case (seq_q.st)
            ST_IDLE: if (start_i) seq_d.st = ST_ACT;
            ST_ACT: begin
                seq_d.st  = ST_ACT_WAIT;
                seq_d.cnt = CNT_W'(WAIT_CYC - 1);
            end
            ST_ACT_WAIT: begin
                if (seq_q.cnt == '0) seq_d.st = ST_WRITE;
                else                 seq_d.cnt = seq_q.cnt - 1'b1;
            end
            ST_WRITE: begin
                seq_d.st   = ST_LANE_SEL;
                seq_d.lane = '0;
            end
            ST_LANE_SEL: begin
                seq_d.tap       = '0;
                seq_d.hunt_fail = 1'b0;
                seq_d.st        = ST_PROBE;
            end
            ST_PROBE: begin
                if (seq_q.tap >= TAP_W'(MAX_TAP)) begin
                    edge_hit = 1'b1;
                end else begin
                    seq_d.st  = ST_RD_WAIT;
                    seq_d.cnt = CNT_W'(WAIT_CYC - 1);
                end
            end
            ST_RD_WAIT: begin
                if (seq_q.cnt == '0) seq_d.st = ST_EVAL;
                else                 seq_d.cnt = seq_q.cnt - 1'b1;
            end
            ST_EVAL: begin
                // Edge when the read outcome matches what this phase hunts for
                if (lane_ok_i != seq_q.hunt_fail) edge_hit = 1'b1;
                else                              seq_d.st = ST_STEP;
            end
            ST_STEP: begin
                seq_d.tap = seq_q.tap + 1'b1;
                seq_d.st  = ST_PROBE;
            end
            ST_MARGIN: begin
                seq_d.tap = seq_q.tap + 1'b1;
                if (seq_q.cnt == '0) begin
                    seq_d.st        = ST_PROBE;
                    seq_d.hunt_fail = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_CENTER_RST: seq_d.st = ST_CENTER_INC;
            ST_CENTER_INC: begin
                if (seq_q.cnt == '0) begin
                    if (seq_q.lane == LANE_W'(LANES - 1)) begin
                        seq_d.st = ST_PRE;
                    end else begin
                        seq_d.lane = seq_q.lane + 1'b1;
                        seq_d.st   = ST_LANE_SEL;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_PRE: begin
                seq_d.st  = ST_PRE_WAIT;
                seq_d.cnt = CNT_W'(WAIT_CYC - 1);
            end
            ST_PRE_WAIT: begin
                if (seq_q.cnt == '0) seq_d.st = ST_FINISH;
                else                 seq_d.cnt = seq_q.cnt - 1'b1;
            end
            ST_FINISH: seq_d.st = ST_IDLE;
            default:   seq_d.st = ST_IDLE;
        endcase

        if (edge_hit) begin
            if (!seq_q.hunt_fail) begin
                rec_min_o = 1'b1;
                seq_d.lo  = seq_q.tap;
                seq_d.st  = ST_MARGIN;
                seq_d.cnt = CNT_W'(MARGIN - 1);
            end else begin
                rec_max_o = 1'b1;
                seq_d.st  = ST_CENTER_RST;
                seq_d.cnt = CNT_W'(mid_w);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end

    // Moore decode of the pulses from the registered state
    assign dly_rst_o = (seq_q.st == ST_LANE_SEL) || (seq_q.st == ST_CENTER_RST);
    assign dly_inc_o = (seq_q.st == ST_STEP) || (seq_q.st == ST_MARGIN) ||
                       ((seq_q.st == ST_CENTER_INC) && (seq_q.cnt != '0));
    assign cmd_act_o = (seq_q.st == ST_ACT);
    assign cmd_wr_o  = (seq_q.st == ST_WRITE);
    assign cmd_rd_o  = (seq_q.st == ST_PROBE) && (seq_q.tap < TAP_W'(MAX_TAP));
    assign cmd_pre_o = (seq_q.st == ST_PRE);
    assign busy_o    = (seq_q.st != ST_IDLE);
    assign done_o    = (seq_q.st == ST_FINISH);
    assign lane_active_o = seq_q.st inside {ST_LANE_SEL, ST_PROBE, ST_RD_WAIT, ST_EVAL,
                                            ST_STEP, ST_MARGIN, ST_CENTER_RST, ST_CENTER_INC};
    assign lane_o = seq_q.lane;
    assign tap_o  = seq_q.tap;

endmodule

// File: rtl/rdly_result_bank.sv
module rdly_result_bank #(
    parameter int LANES = 4,
    parameter int TAP_W = 6,
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANE_W-1:0]      lane_i,
    input  logic                   rec_min_i,
    input  logic                   rec_max_i,
    input  logic [TAP_W-1:0]       tap_i,
    output logic [LANES*TAP_W-1:0] min_taps_o,
    output logic [LANES*TAP_W-1:0] max_taps_o
);
    for (genvar n = 0; n < LANES; n++) begin : g_lane
        logic [TAP_W-1:0] lo_d, lo_q, hi_d, hi_q;
        logic hit;
        assign hit = (lane_i == LANE_W'(n));
        always_comb begin
            lo_d = (hit && rec_min_i) ? tap_i : lo_q;
            hi_d = (hit && rec_max_i) ? tap_i : hi_q;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q <= '0;
                hi_q <= '0;
            end else begin
                lo_q <= lo_d;
                hi_q <= hi_d;
            end
        end
        assign min_taps_o[n*TAP_W +: TAP_W] = lo_q;
        assign max_taps_o[n*TAP_W +: TAP_W] = hi_q;
    end

endmodule

// File: rtl/rdly_calibrator.sv
module rdly_calibrator #(
    parameter int LANES     = 4,
    parameter int PHASES    = 4,
    parameter bit LONG_LINE = 1'b0,
    parameter int WAIT_CYC  = 15,
    localparam int MAX_TAP = LONG_LINE ? 512 : 32,
    localparam int MARGIN  = LONG_LINE ? 8 : 1,
    localparam int TAP_W   = $clog2(MAX_TAP + MARGIN + 1),
    localparam int LANE_W  = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int DATA_W  = PHASES * 2 * LANES * 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [DATA_W-1:0]      rd_data,
    output logic [LANES-1:0]       lane_sel,
    output logic                   dly_rst,
    output logic                   dly_inc,
    output logic                   cmd_act,
    output logic                   cmd_wr,
    output logic                   cmd_rd,
    output logic                   cmd_pre,
    output logic [DATA_W-1:0]      wr_data,
    output logic                   busy,
    output logic                   done,
    output logic [LANES*TAP_W-1:0] min_taps,
    output logic [LANES*TAP_W-1:0] max_taps
);
    logic [LANE_W-1:0] lane_idx;
    logic              lane_active;
    logic [TAP_W-1:0]  cur_tap;
    logic              rec_min, rec_max, lane_ok;

    rdly_pattern #(.LANES(LANES), .PHASES(PHASES)) u_pattern (
        .pattern_o (wr_data)
    );

    rdly_match #(.LANES(LANES), .PHASES(PHASES)) u_match (
        .rd_data_i (rd_data),
        .pattern_i (wr_data),
        .lane_i    (lane_idx),
        .lane_ok_o (lane_ok)
    );

    rdly_seq #(
        .LANES(LANES), .MAX_TAP(MAX_TAP), .MARGIN(MARGIN), .WAIT_CYC(WAIT_CYC)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .lane_ok_i     (lane_ok),
        .lane_o        (lane_idx),
        .lane_active_o (lane_active),
        .tap_o         (cur_tap),
        .rec_min_o     (rec_min),
        .rec_max_o     (rec_max),
        .dly_rst_o     (dly_rst),
        .dly_inc_o     (dly_inc),
        .cmd_act_o     (cmd_act),
        .cmd_wr_o      (cmd_wr),
        .cmd_rd_o      (cmd_rd),
        .cmd_pre_o     (cmd_pre),
        .busy_o        (busy),
        .done_o        (done)
    );

    rdly_result_bank #(.LANES(LANES), .TAP_W(TAP_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .lane_i     (lane_idx),
        .rec_min_i  (rec_min),
        .rec_max_i  (rec_max),
        .tap_i      (cur_tap),
        .min_taps_o (min_taps),
        .max_taps_o (max_taps)
    );

    // Lane n drives the delay line at mask bit LANES-1-n
    assign lane_sel = lane_active ? (LANES'(1) << (LANE_W'(LANES - 1) - lane_idx)) : '0;

endmodule

// File: rtl/rdly_calibrator_chk.sv
module rdly_calibrator_chk #(
    parameter int LANES = 4,
    parameter int TAP_W = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [LANES-1:0]       lane_sel,
    input logic                   dly_rst,
    input logic                   dly_inc,
    input logic                   cmd_act,
    input logic                   cmd_wr,
    input logic                   cmd_rd,
    input logic                   cmd_pre,
    input logic                   busy,
    input logic                   done,
    input logic [LANES*TAP_W-1:0] min_taps,
    input logic [LANES*TAP_W-1:0] max_taps
);
    // R4
    read_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rd |-> $past(dly_rst || dly_inc));

    // R4
    quiet_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rd |=> !(dly_rst || dly_inc));

    // R2
    single_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_act, cmd_wr, cmd_rd, cmd_pre}));

    // R3
    one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_rst || dly_inc) |-> ($countones(lane_sel) == 1));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    act_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_act |=> busy && !cmd_act);

    for (genvar n = 0; n < LANES; n++) begin : g_order
        // R10
        edge_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            done |-> (max_taps[n*TAP_W +: TAP_W] >= min_taps[n*TAP_W +: TAP_W]));
    end

endmodule

bind rdly_calibrator rdly_calibrator_chk #(.LANES(LANES), .TAP_W(TAP_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lane_sel (lane_sel),
    .dly_rst  (dly_rst),
    .dly_inc  (dly_inc),
    .cmd_act  (cmd_act),
    .cmd_wr   (cmd_wr),
    .cmd_rd   (cmd_rd),
    .cmd_pre  (cmd_pre),
    .busy     (busy),
    .done     (done),
    .min_taps (min_taps),
    .max_taps (max_taps)
);

// File: tb/rdly_calibrator_bench.sv
module rdly_calibrator_bench;
    localparam int CLK_NS = 10;
    localparam int LANES  = 4;
    localparam int PHASES = 4;
    localparam int NB     = PHASES * 2 * LANES;
    localparam int DW     = NB * 8;
    localparam int MAXT   = 32;
    localparam int MARG   = 1;
    localparam int TW     = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [DW-1:0] rd_data = '0;
    logic [LANES-1:0] lane_sel;
    logic dly_rst, dly_inc, cmd_act, cmd_wr, cmd_rd, cmd_pre, busy, done;
    logic [DW-1:0] wr_data;
    logic [LANES*TW-1:0] min_taps, max_taps;

    rdly_calibrator u_rdly_calibrator (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_data(rd_data),
        .lane_sel(lane_sel), .dly_rst(dly_rst), .dly_inc(dly_inc),
        .cmd_act(cmd_act), .cmd_wr(cmd_wr), .cmd_rd(cmd_rd), .cmd_pre(cmd_pre),
        .wr_data(wr_data), .busy(busy), .done(done),
        .min_taps(min_taps), .max_taps(max_taps)
    );

    always #(CLK_NS/2) clk = ~clk;

    typedef struct {int lane; int mn; int mx; int fin;} exp_t;
    exp_t sb_q[$];

    int n_cmp = 0, n_bad = 0;
    int win_lo[LANES], win_hi[LANES];
    int mdl_dly[LANES];
    int since_rd = 1000, since_act = 1000, since_pre = 1000;
    int rst_cnt = 0, act_cnt = 0;
    bit prev_pulse = 0, run_done = 0;
    logic [DW-1:0] pat;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] make_pattern();
        logic [DW-1:0] r;
        logic [31:0] v;
        r = '0;
        v = 32'd42;
        for (int i = 0; i < NB; i++) begin
            v = v * 32'd1664525 + 32'd1013904223;
            r[i*8 +: 8] = v[7:0];
        end
        return r;
    endfunction

    function automatic bit passes(input int n, input int tap);
        return (tap >= win_lo[n]) && (tap <= win_hi[n]);
    endfunction

    // R5/R6: valid bytes follow the per-lane window; other cycles carry the opposite outcome
    function automatic logic [DW-1:0] build_rd(input bit valid);
        logic [DW-1:0] r;
        r = pat;
        for (int n = 0; n < LANES; n++) begin
            bit good;
            good = passes(n, mdl_dly[LANES-1-n]);
            if (!valid) good = !good;
            if (!good)
                for (int p = 0; p < PHASES; p++) begin
                    r[(p*2*LANES + n)*8 +: 8]         = ~pat[(p*2*LANES + n)*8 +: 8];
                    r[(p*2*LANES + n + LANES)*8 +: 8] = ~pat[(p*2*LANES + n + LANES)*8 +: 8];
                end
        end
        return r;
    endfunction

    // Monitor and scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            since_rd++; since_act++; since_pre++;
            if (cmd_rd) begin
                chk("R4", "read one cycle after delay pulse", int'(prev_pulse), 1);
                since_rd = 0;
            end
            if (dly_rst || dly_inc)
                chk("R4", "no delay pulse while read pending", int'(since_rd > 16), 1);
            if (dly_rst) begin
                chk("R3", "lane select mask", int'(lane_sel),
                    1 << (LANES - 1 - ((rst_cnt / 2) % LANES)));
                rst_cnt++;
            end
            if (cmd_act) begin
                since_act = 0;
                act_cnt++;
            end
            if (cmd_wr) begin
                chk("R2", "activate to write gap", since_act, 16);
                n_cmp++;
                if (wr_data !== pat) begin
                    n_bad++;
                    $display("FAIL R2 pattern: actual %h expected %h", wr_data, pat);
                end
            end
            if (cmd_pre) since_pre = 0;
            if (done) begin
                chk("R10", "precharge to done gap", since_pre, 16);
                chk("R11", "activates per run", act_cnt, 1);
                for (int i = 0; i < LANES; i++) begin
                    exp_t e;
                    e = sb_q.pop_front();
                    // R7 R8: recorded edges
                    chk("R7", $sformatf("lane %0d min", e.lane),
                        int'(min_taps[e.lane*TW +: TW]), e.mn);
                    chk("R8", $sformatf("lane %0d max", e.lane),
                        int'(max_taps[e.lane*TW +: TW]), e.mx);
                    // R9: centred delay
                    chk("R9", $sformatf("lane %0d final delay", e.lane),
                        mdl_dly[LANES-1-e.lane], e.fin);
                end
                run_done = 1;
            end
            for (int k = 0; k < LANES; k++)
                if (lane_sel[k]) begin
                    if (dly_rst) mdl_dly[k] = 0;
                    if (dly_inc) mdl_dly[k] = mdl_dly[k] + 1;
                end
            prev_pulse = dly_rst || dly_inc;
            rd_data = build_rd(since_rd == 16);
        end
    end

    task automatic run_case(input int lo0, input int hi0, input int lo1, input int hi1,
                            input int lo2, input int hi2, input int lo3, input int hi3);
        win_lo = '{lo0, lo1, lo2, lo3};
        win_hi = '{hi0, hi1, hi2, hi3};
        for (int n = 0; n < LANES; n++) begin
            exp_t e;
            int t;
            t = 0;
            while (t < MAXT && !passes(n, t)) t++;
            e.mn = t;
            t = t + MARG;
            while (t < MAXT && passes(n, t)) t++;
            e.mx = t;
            e.fin = (e.mn + e.mx) / 2;
            e.lane = n;
            sb_q.push_back(e);
        end
        act_cnt = 0;
        run_done = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (40) @(negedge clk);
        start = 1'b1;          // R11: ignored while busy
        @(negedge clk); start = 1'b0;
        wait (run_done);
        repeat (2) @(negedge clk);
        chk("R10", "busy low after done", int'(busy), 0);
    endtask

    initial begin
        for (int k = 0; k < LANES; k++) mdl_dly[k] = 0;
        pat = make_pattern();
        repeat (3) @(negedge clk);
        // R1: quiet under reset
        chk("R1", "pulses under reset",
            int'({dly_rst, dly_inc, cmd_act, cmd_wr, cmd_rd, cmd_pre, done, busy}), 0);
        chk("R1", "lane_sel under reset", int'(lane_sel), 0);
        chk("R1", "min taps under reset", int'(min_taps), 0);
        chk("R1", "max taps under reset", int'(max_taps), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_case(0, 5, 5, 12, 3, 3, 10, 40);
        run_case(50, 60, 31, 31, 1, 2, 20, 25);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R10 watchdog: actual 0 expected 1 done pulses");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule